// File: doc/BRIEF.md
# Coarse-Period 10-bit Up-Counter Timer

This block is a 10-bit up-counter that advances on one of several count-enable sources. It can also compare its count against a coarse period value. Software programs it through a narrow write port that reaches three addresses:

- a control word holding run/stop, freeze, source select and period code;
- an option word holding the clear-on-match select, the output-pin mode and the pin's start level;
- a write-one-to-clear port for the two sticky event flags.

The count is always visible on an output bus. Reading it never disturbs it.

The count sources are five pre-divided clock-enable pulses from the surrounding clock tree, plus an external pin. The external pin is resynchronised and counted on a chosen edge. The 3-bit period code is matched against the three most significant count bits, so periods are whole multiples of 128 counts, and code zero means the full 1024-count range. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `coarse_tmr`

## Requirements
- R1: After reset the count, both event flags and the output pin are all zero, and every register holds zero.
- R2: With the timer running and not frozen, the count rises by exactly one for each pulse on the selected enable. Source codes are 000 en_div4, 001 en_sys, 010 en_hf16, 011 en_hf64 and 100 en_sub. Pulses on unselected enables have no effect.
- R3: Source code 101 is reserved. While it is selected, the count does not advance for any input.
- R4: Source code 110 counts rising edges of ext_clk and code 111 counts falling edges. Each edge is counted once, no later than three clock cycles after it reaches the pin.
- R5: Control bit 1 freezes the count at its present value. Clearing the bit resumes counting from that value.
- R6: Control bit 0 is the run bit. A write that takes it from 0 to 1 sets the count to zero on that clock edge. Taking it from 1 to 0 stops counting and keeps the count.
- R7: Period code p (control bits 7:5) from 1 to 7 with option bit 0 clear: the count runs 0 to 128·p−1 and returns to 0. On the count that would reach 128·p, the match flag is set.
- R8: Period code 0 gives a full 1024-count period. Counting from 1023 goes to 0 and sets both the match flag and the overflow flag.
- R9: With option bit 0 set, reaching 128·p only sets the match flag and counting continues. A count from 1023 wraps to 0 and sets the overflow flag.
- R10: Both flags are sticky. A write to address 2 clears the match flag with bit 0 and the overflow flag with bit 1. A new event in the same cycle wins over the clear.
- R11: With option bit 1 (pin mode) set, tm_out is loaded with option bit 2 on a run-bit 0→1 write and toggles on every period match. With option bit 1 clear, tm_out is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 options, 2 flag clear |
| wr_data | input | 8 | Write data |
| en_div4 | input | 1 | Count enable, system clock / 4 rate |
| en_sys | input | 1 | Count enable, system clock rate |
| en_hf16 | input | 1 | Count enable, high clock / 16 rate |
| en_hf64 | input | 1 | Count enable, high clock / 64 rate |
| en_sub | input | 1 | Count enable, sub clock rate |
| ext_clk | input | 1 | External count pin, asynchronous |
| count | output | 10 | Live counter value |
| match_flag | output | 1 | Sticky period-match flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| tm_out | output | 1 | Compare-match output pin |

## Verification
A corrupted count shows on the count bus at the next sampling point after the enable that produced it, because each check follows a known number of enable pulses. A wrong source decode or a lost freeze shows up as an off-by-N count at that same point. Period logic errors surface only at the 128·p or 1023 boundary, so the bench stops one count short of each boundary and one count after it. This exposes an early or late match, a missed clear, or a flag set at the wrong time within one enable of the fault. Faults in the output pin show as a wrong level right after the turn-on write or after the first match.

// File: rtl/coarse_tmr_pkg.sv
package coarse_tmr_pkg;
  localparam int SEL_W = 3;
  localparam int PER_W = 3;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [SEL_W-1:0] {
    SRC_DIV4 = 3'b000,
    SRC_SYS  = 3'b001,
    SRC_HF16 = 3'b010,
    SRC_HF64 = 3'b011,
    SRC_SUB  = 3'b100,
    SRC_NONE = 3'b101,
    SRC_XRISE = 3'b110,
    SRC_XFALL = 3'b111
  } clk_src_e;

  typedef struct packed {
    logic [PER_W-1:0] period;
    clk_src_e         src;
    logic             freeze;
    logic             run;
  } ctrl_t;

  typedef struct packed {
    logic pin_init;
    logic pin_mode;
    logic keep_on_match;
  } opt_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_OPT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;
endpackage

// File: rtl/coarse_tmr_regs.sv
module coarse_tmr_regs
  import coarse_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output opt_t              opt,
  output logic              run_rise,
  output logic              clr_match,
  output logic              clr_ovf
);
  logic wr_ctrl, wr_opt, wr_clr;
  ctrl_t ctrl_new;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_opt   = wr_en && (wr_addr == A_OPT);
  assign wr_clr   = wr_en && (wr_addr == A_CLR);
  assign ctrl_new = ctrl_t'(wr_data);

  assign run_rise  = wr_ctrl && ctrl_new.run && !ctrl.run;
  assign clr_match = wr_clr && wr_data[0];
  assign clr_ovf   = wr_clr && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      opt  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_new;
      if (wr_opt)  opt  <= opt_t'(wr_data[2:0]);
    end
  end
endmodule

// File: rtl/coarse_tmr_srcsel.sv
module coarse_tmr_srcsel
  import coarse_tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     en_div4,
  input  logic     en_sys,
  input  logic     en_hf16,
  input  logic     en_hf64,
  input  logic     en_sub,
  input  logic     ext_clk,
  output logic     tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pin_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= ext_clk;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= pin_s;
  end

  always_comb begin
    unique case (src)
      SRC_DIV4:  tick = en_div4;
      SRC_SYS:   tick = en_sys;
      SRC_HF16:  tick = en_hf16;
      SRC_HF64:  tick = en_hf64;
      SRC_SUB:   tick = en_sub;
      SRC_XRISE: tick = pin_s && !last_q;
      SRC_XFALL: tick = !pin_s && last_q;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/coarse_tmr_core.sv
module coarse_tmr_core
  import coarse_tmr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  opt_t             opt,
  input  logic             run_rise,
  input  logic             clr_match,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic             match_flag,
  output logic             ovf_flag,
  output logic             pin_q
);
  localparam int LOW_W = CNT_W - PER_W;

  logic             step;
  logic             at_top;
  logic             hit;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] target;

  assign step   = tick && ctrl.run && !ctrl.freeze && !run_rise;
  assign nxt    = count + 1'b1;
  assign at_top = &count;
  assign target = {ctrl.period, {LOW_W{1'b0}}};
  assign hit    = (ctrl.period == '0) ? at_top : (nxt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      match_flag <= 1'b0;
      ovf_flag   <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      if (run_rise)                        count <= '0;
      else if (step && hit && !opt.keep_on_match) count <= '0;
      else if (step)                       count <= nxt;

      if (step && hit)    match_flag <= 1'b1;
      else if (clr_match) match_flag <= 1'b0;

      if (step && at_top) ovf_flag <= 1'b1;
      else if (clr_ovf)   ovf_flag <= 1'b0;

      if (run_rise)         pin_q <= opt.pin_init;
      else if (step && hit) pin_q <= !pin_q;
    end
  end
endmodule

// File: rtl/coarse_tmr.sv
module coarse_tmr
  import coarse_tmr_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en_div4,
  input  logic              en_sys,
  input  logic              en_hf16,
  input  logic              en_hf64,
  input  logic              en_sub,
  input  logic              ext_clk,
  output logic [CNT_W-1:0]  count,
  output logic              match_flag,
  output logic              ovf_flag,
  output logic              tm_out
);
  ctrl_t ctrl;
  opt_t  opt;
  logic  run_rise, clr_match, clr_ovf, tick, pin_q;

  coarse_tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .opt(opt), .run_rise(run_rise),
    .clr_match(clr_match), .clr_ovf(clr_ovf)
  );

  coarse_tmr_srcsel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .src(ctrl.src), .en_div4(en_div4),
    .en_sys(en_sys), .en_hf16(en_hf16), .en_hf64(en_hf64),
    .en_sub(en_sub), .ext_clk(ext_clk), .tick(tick)
  );

  coarse_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl), .opt(opt),
    .run_rise(run_rise), .clr_match(clr_match), .clr_ovf(clr_ovf),
    .count(count), .match_flag(match_flag), .ovf_flag(ovf_flag),
    .pin_q(pin_q)
  );

  assign tm_out = opt.pin_mode && pin_q;
endmodule

// File: rtl/coarse_tmr_chk.sv
module coarse_tmr_chk
  import coarse_tmr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic              match_flag,
  input logic              ovf_flag,
  input logic              tm_out,
  input ctrl_t             ctrl,
  input opt_t              opt
);
  logic clr_m_w;
  assign clr_m_w = wr_en && (wr_addr == A_CLR) && wr_data[0];

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == $past(count) + 1'b1) || (count == '0));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && ctrl.src == SRC_NONE && !wr_en) |=> $stable(count));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.freeze && !wr_en) |=> $stable(count));

  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_en) |=> $stable(count));

  p_wrap_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count) == {CNT_W{1'b1}}));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_m_w) |=> match_flag);

  p_pin_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[0] && !ctrl.run && opt.pin_mode)
      |=> (tm_out == $past(opt.pin_init)));
endmodule

bind coarse_tmr coarse_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .match_flag(match_flag),
  .ovf_flag(ovf_flag), .tm_out(tm_out), .ctrl(ctrl), .opt(opt)
);

// File: tb/coarse_tmr_tb.sv
module coarse_tmr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] en_v = '0;
  logic       ext_clk = 1'b0;
  logic [9:0] count;
  logic       match_flag, ovf_flag, tm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coarse_tmr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_div4(en_v[0]), .en_sys(en_v[1]),
    .en_hf16(en_v[2]), .en_hf64(en_v[3]), .en_sub(en_v[4]),
    .ext_clk(ext_clk), .count(count), .match_flag(match_flag),
    .ovf_flag(ovf_flag), .tm_out(tm_out)
  );

  // {src[15:13], pulsed line[12:10] (5 = all lines), pulses[9:5], expected[4:0]}
  localparam logic [15:0] VECS [0:7] = '{
    {3'd0, 3'd0, 5'd5, 5'd5},
    {3'd0, 3'd1, 5'd5, 5'd0},
    {3'd1, 3'd1, 5'd3, 5'd3},
    {3'd2, 3'd2, 5'd4, 5'd4},
    {3'd3, 3'd3, 5'd2, 5'd2},
    {3'd4, 3'd4, 5'd6, 5'd6},
    {3'd4, 3'd0, 5'd6, 5'd0},
    {3'd5, 3'd5, 5'd9, 5'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input bit run, input bit frz, input int src, input int per);
    wr(2'd0, {per[2:0], src[2:0], frz, run});
  endtask

  task automatic tick_n(input int line, input int n);
    if (n > 0) begin
      @(negedge clk);
      en_v = (line == 5) ? 5'b11111 : (5'b00001 << line);
      repeat (n) @(negedge clk);
      en_v = '0;
    end
  endtask

  task automatic pin_to(input bit v);
    @(negedge clk);
    ext_clk = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 match", match_flag, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 pin", tm_out, 0);

    // R2 / R3 table walk
    for (int i = 0; i < 8; i++) begin
      ctl(0, 0, VECS[i][15:13], 0);
      ctl(1, 0, VECS[i][15:13], 0);
      tick_n(VECS[i][12:10], VECS[i][9:5]);
      chk((VECS[i][15:13] == 3'd5) ? "R3 reserved" : "R2 source", count, VECS[i][4:0]);
    end

    // R4 external pin edges
    ctl(0, 0, 6, 0); ctl(1, 0, 6, 0);
    for (int k = 0; k < 3; k++) begin pin_to(1); pin_to(0); end
    chk("R4 rising", count, 3);
    ctl(0, 0, 7, 0); ctl(1, 0, 7, 0);
    for (int k = 0; k < 2; k++) begin pin_to(1); pin_to(0); end
    chk("R4 falling", count, 2);

    // R5 freeze, R6 run bit
    ctl(0, 0, 1, 0); ctl(1, 0, 1, 0);
    tick_n(1, 10);
    chk("R5 before freeze", count, 10);
    ctl(1, 1, 1, 0);
    tick_n(1, 5);
    chk("R5 frozen", count, 10);
    ctl(1, 0, 1, 0);
    tick_n(1, 3);
    chk("R5 resumed", count, 13);
    ctl(0, 0, 1, 0);
    tick_n(1, 4);
    chk("R6 off keeps", count, 13);
    ctl(1, 0, 1, 0);
    chk("R6 on clears", count, 0);

    // R7 + R11: period code 1, clear on match, pin mode, init high
    wr(2'd1, 8'b0000_0110);
    ctl(0, 0, 1, 1); ctl(1, 0, 1, 1);
    chk("R11 init level", tm_out, 1);
    tick_n(1, 127);
    chk("R7 before match", count, 127);
    chk("R7 no flag yet", match_flag, 0);
    tick_n(1, 1);
    chk("R7 cleared", count, 0);
    chk("R7 flag", match_flag, 1);
    chk("R11 toggled", tm_out, 0);
    tick_n(1, 128);
    chk("R11 toggled back", tm_out, 1);
    chk("R7 no overflow", ovf_flag, 0);

    // R8 full period
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h00);
    chk("R11 gated low", tm_out, 0);
    ctl(0, 0, 1, 0); ctl(1, 0, 1, 0);
    tick_n(1, 1023);
    chk("R8 at top", count, 1023);
    chk("R8 no match yet", match_flag, 0);
    tick_n(1, 1);
    chk("R8 wrapped", count, 0);
    chk("R8 match", match_flag, 1);
    chk("R8 ovf", ovf_flag, 1);

    // R10 write-one-to-clear
    wr(2'd2, 8'h01);
    chk("R10 match cleared", match_flag, 0);
    chk("R10 ovf kept", ovf_flag, 1);
    wr(2'd2, 8'h02);
    chk("R10 ovf cleared", ovf_flag, 0);

    // R9 keep counting on match
    wr(2'd1, 8'h01);
    ctl(0, 0, 1, 2); ctl(1, 0, 1, 2);
    tick_n(1, 256);
    chk("R9 passes match", count, 256);
    chk("R9 match", match_flag, 1);
    chk("R9 no ovf", ovf_flag, 0);
    tick_n(1, 767);
    chk("R9 top", count, 1023);
    tick_n(1, 1);
    chk("R9 wrap", count, 0);
    chk("R9 ovf", ovf_flag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule